// File: doc/BRIEF.md
# Integer Register Specifier Legality Checker

This block sits in the decode stage of an integer core that is built either with the full 32-register base or with the reduced 16-register base, the choice fixed at elaboration. From a 32-bit instruction word it pulls out the destination and two source register specifiers, narrows each to the configured index width and raises an illegal-instruction flag when a field that the current format uses names a register the reduced base lacks. When the compressed-format flag is set, the 3-bit register fields are widened to registers 8 to 15, which exist in both bases and are never flagged.

The block also holds the machine ISA register. Its two base-ISA bits are fixed by the configuration. Reset loads them, and a software write cannot change them. The other bits take the written value. Opcode decode, register storage and the trap sequence belong to neighbouring blocks. The per-field enables tell this block which fields the current format uses.

Top module: `regspec_check`

## Requirements
- R1: The index width is 4 bits when `REDUCED` is 1 and 5 bits when it is 0. For an uncompressed word, `rd_idx_o`, `rs1_idx_o` and `rs2_idx_o` equal the low index-width bits of instruction bits 11:7, 19:15 and 24:20 respectively, whether or not the field is enabled.
- R2: With `REDUCED`=1, an enabled uncompressed field whose bit 4 is 1 (registers 16 to 31) drives `illegal_o` to 1.
- R3: With `REDUCED`=0, `illegal_o` is 0 for every specifier value. Registers 0, 1 and 2 are never flagged in either configuration.
- R4: A field whose enable (`use_rd_i`, `use_rs1_i`, `use_rs2_i`) is 0 never raises `illegal_o`, whatever its value.
- R5: With `compressed_i`=1, `rd_idx_o` and `rs1_idx_o` are 8 plus instruction bits 9:7, `rs2_idx_o` is 8 plus instruction bits 4:2, and `illegal_o` is 0.
- R6: `illegal_o` is combinational: it is the OR of the per-field results for the inputs present in the same cycle.
- R7: After reset, `misa_o` bit 4 (reduced base) equals `REDUCED`, bit 8 (full base) equals its inverse, and all other bits are 0.
- R8: A cycle with `misa_we_i`=1 updates `misa_o` at the next rising edge. Bits 4 and 8 keep their configured values whatever is written, and every other bit takes the written value. With `misa_we_i`=0, `misa_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word |
| compressed_i | input | 1 | Word is in compressed format (3-bit register fields) |
| use_rd_i | input | 1 | Format uses the destination field |
| use_rs1_i | input | 1 | Format uses the first source field |
| use_rs2_i | input | 1 | Format uses the second source field |
| rd_idx_o | output | IDX_W | Narrowed destination index |
| rs1_idx_o | output | IDX_W | Narrowed first source index |
| rs2_idx_o | output | IDX_W | Narrowed second source index |
| illegal_o | output | 1 | Reserved register specifier in a used field |
| misa_we_i | input | 1 | Software write strobe for the ISA register |
| misa_wdata_i | input | XLEN | Software write data |
| misa_o | output | XLEN | Current ISA register value |

## Verification
The specifier path has no state, so any fault in the narrowing or the legality test appears in the same cycle on the index outputs or on `illegal_o`. A sweep over all 32 values of each field, in both configurations, exposes it at once. The ISA register is the only state. A wrong reset value, or a write that reaches a base bit, shows on `misa_o` one edge after reset or after the write. Writes of all ones, all zeros and mixed patterns make sure no bit can hide.

// File: rtl/regspec_pkg.sv
package regspec_pkg;
  localparam int unsigned SPEC_W     = 5;
  localparam int unsigned CSPEC_W    = 3;
  localparam int unsigned NFIELD     = 3;
  localparam int unsigned MISA_E_POS = 4;
  localparam int unsigned MISA_I_POS = 8;

  localparam int unsigned RD_LSB  = 7;
  localparam int unsigned RS1_LSB = 15;
  localparam int unsigned RS2_LSB = 20;
  localparam int unsigned CRD_LSB = 7;
  localparam int unsigned CRS2_LSB = 2;

  typedef enum logic [1:0] {
    FLD_RD  = 2'd0,
    FLD_RS1 = 2'd1,
    FLD_RS2 = 2'd2
  } field_e;

  function automatic int unsigned idx_width(input bit reduced);
    return reduced ? 4 : 5;
  endfunction

  function automatic int unsigned full_lsb(input int unsigned f);
    case (f)
      0:       return RD_LSB;
      1:       return RS1_LSB;
      default: return RS2_LSB;
    endcase
  endfunction

  function automatic int unsigned comp_lsb(input int unsigned f);
    return (f == 2) ? CRS2_LSB : CRD_LSB;
  endfunction
endpackage

// File: rtl/spec_narrow.sv
module spec_narrow #(
  parameter bit          REDUCED = 1'b1,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [regspec_pkg::SPEC_W-1:0] spec_i,
  input  logic                           en_i,
  output logic [IDX_W-1:0]               idx_o,
  output logic                           bad_o
);
  localparam int unsigned SW = regspec_pkg::SPEC_W;

  assign idx_o = spec_i[IDX_W-1:0];

  generate
    if (REDUCED) begin : g_reduced
      assign bad_o = en_i & spec_i[SW-1];
    end else begin : g_full
      logic unused_en;
      assign unused_en = en_i;
      assign bad_o     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/creg_widen.sv
module creg_widen #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [regspec_pkg::CSPEC_W-1:0] cspec_i,
  output logic [IDX_W-1:0]                idx_o
);
  logic [regspec_pkg::SPEC_W-1:0] wide;

  // compressed fields address registers 8..15
  assign wide  = {2'b01, cspec_i};
  assign idx_o = wide[IDX_W-1:0];
endmodule

// File: rtl/misa_base.sv
module misa_base #(
  parameter bit          REDUCED = 1'b1,
  parameter int unsigned XLEN    = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] misa_o
);
  localparam int unsigned EP = regspec_pkg::MISA_E_POS;
  localparam int unsigned IP = regspec_pkg::MISA_I_POS;
  localparam logic [XLEN-1:0] BASE_MASK = (XLEN'(1) << EP) | (XLEN'(1) << IP);
  localparam logic [XLEN-1:0] BASE_VAL  =
      (XLEN'(REDUCED) << EP) | (XLEN'(!REDUCED) << IP);

  logic [XLEN-1:0] misa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misa_q <= BASE_VAL;
    end else if (we_i) begin
      // base bits recomputed from configuration on every write
      misa_q <= (wdata_i & ~BASE_MASK) | BASE_VAL;
    end
  end

  assign misa_o = misa_q;

  // R8
  misa_base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(misa_q[EP]) && $stable(misa_q[IP]));

  // R8
  misa_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((misa_q & ~BASE_MASK) == ($past(wdata_i) & ~BASE_MASK)));

  // R8
  misa_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(misa_q));

  // R7
  misa_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misa_q[EP] != misa_q[IP]);
endmodule

// File: rtl/regspec_check.sv
module regspec_check #(
  parameter bit          REDUCED = 1'b1,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IDX_W   = regspec_pkg::idx_width(REDUCED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      instr_i,
  input  logic             compressed_i,
  input  logic             use_rd_i,
  input  logic             use_rs1_i,
  input  logic             use_rs2_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [IDX_W-1:0] rs1_idx_o,
  output logic [IDX_W-1:0] rs2_idx_o,
  output logic             illegal_o,
  input  logic             misa_we_i,
  input  logic [XLEN-1:0]  misa_wdata_i,
  output logic [XLEN-1:0]  misa_o
);
  import regspec_pkg::*;

  localparam int unsigned NF = NFIELD;

  logic [NF-1:0]            fld_en;
  logic [NF-1:0]            fld_bad;
  logic [IDX_W-1:0]         full_idx [NF];
  logic [IDX_W-1:0]         comp_idx [NF];
  logic [IDX_W-1:0]         sel_idx  [NF];

  assign fld_en = {use_rs2_i, use_rs1_i, use_rd_i};

  generate
    for (genvar f = 0; f < NF; f++) begin : g_fld
      localparam int unsigned FL = full_lsb(f);
      localparam int unsigned CL = comp_lsb(f);

      spec_narrow #(.REDUCED(REDUCED), .IDX_W(IDX_W)) u_narrow (
        .spec_i (instr_i[FL +: SPEC_W]),
        .en_i   (fld_en[f] & ~compressed_i),
        .idx_o  (full_idx[f]),
        .bad_o  (fld_bad[f])
      );

      creg_widen #(.IDX_W(IDX_W)) u_widen (
        .cspec_i (instr_i[CL +: CSPEC_W]),
        .idx_o   (comp_idx[f])
      );

      assign sel_idx[f] = compressed_i ? comp_idx[f] : full_idx[f];
    end
  endgenerate

  assign rd_idx_o  = sel_idx[FLD_RD];
  assign rs1_idx_o = sel_idx[FLD_RS1];
  assign rs2_idx_o = sel_idx[FLD_RS2];
  assign illegal_o = |fld_bad;

  misa_base #(.REDUCED(REDUCED), .XLEN(XLEN)) u_misa (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (misa_we_i),
    .wdata_i (misa_wdata_i),
    .misa_o  (misa_o)
  );

  // R5
  comp_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compressed_i |-> !illegal_o);

  // R4
  unused_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(use_rd_i || use_rs1_i || use_rs2_i) |-> !illegal_o);

  // R2
  reserved_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ((use_rd_i && instr_i[11]) || (use_rs1_i && instr_i[19])
                   || (use_rs2_i && instr_i[24])));

  // R3
  full_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misa_o[MISA_I_POS] |-> !illegal_o);

  // R5
  comp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compressed_i |-> (rd_idx_o[3] && rs2_idx_o[3] && (rd_idx_o == rs1_idx_o)));
endmodule

// File: tb/tb_regspec_check.sv
module tb_regspec_check;
  localparam int unsigned XLEN = 32;

  typedef struct {
    logic [4:0]      rd_r, rs1_r, rs2_r, rd_f, rs1_f, rs2_f;
    logic            ill_r, ill_f;
    logic [XLEN-1:0] misa_r, misa_f;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic comp = 1'b0, en_rd = 1'b0, en_rs1 = 1'b0, en_rs2 = 1'b0;
  logic we = 1'b0;
  logic [XLEN-1:0] wdata = '0;

  logic [3:0] rd_r, rs1_r, rs2_r;
  logic [4:0] rd_f, rs1_f, rs2_f;
  logic ill_r, ill_f;
  logic [XLEN-1:0] misa_r, misa_f;

  item_t q[$];
  int n_chk = 0, n_err = 0;
  logic [XLEN-1:0] m_r, m_f;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regspec_check #(.REDUCED(1'b1), .XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .compressed_i(comp),
    .use_rd_i(en_rd), .use_rs1_i(en_rs1), .use_rs2_i(en_rs2),
    .rd_idx_o(rd_r), .rs1_idx_o(rs1_r), .rs2_idx_o(rs2_r), .illegal_o(ill_r),
    .misa_we_i(we), .misa_wdata_i(wdata), .misa_o(misa_r));

  regspec_check #(.REDUCED(1'b0), .XLEN(XLEN)) dut_f (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .compressed_i(comp),
    .use_rd_i(en_rd), .use_rs1_i(en_rs1), .use_rs2_i(en_rs2),
    .rd_idx_o(rd_f), .rs1_idx_o(rs1_f), .rs2_idx_o(rs2_f), .illegal_o(ill_f),
    .misa_we_i(we), .misa_wdata_i(wdata), .misa_o(misa_f));

  function automatic logic [XLEN-1:0] legal_misa(input logic [XLEN-1:0] w, input bit red);
    logic [XLEN-1:0] r;
    r = w;
    r[4] = red;
    r[8] = !red;
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: apply stimulus after a rising edge, push the expected outcome
  task automatic drive(input logic [31:0] w, input logic c, input logic [2:0] en,
                       input logic wr, input logic [XLEN-1:0] wd, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    instr = w; comp = c; en_rd = en[0]; en_rs1 = en[1]; en_rs2 = en[2];
    we = wr; wdata = wd;
    if (c) begin
      it.rd_f  = {2'b01, w[9:7]};
      it.rs1_f = {2'b01, w[9:7]};
      it.rs2_f = {2'b01, w[4:2]};
      it.ill_r = 1'b0;
    end else begin
      it.rd_f  = w[11:7];
      it.rs1_f = w[19:15];
      it.rs2_f = w[24:20];
      it.ill_r = (en[0] & w[11]) | (en[1] & w[19]) | (en[2] & w[24]);
    end
    it.rd_r  = {1'b0, it.rd_f[3:0]};
    it.rs1_r = {1'b0, it.rs1_f[3:0]};
    it.rs2_r = {1'b0, it.rs2_f[3:0]};
    it.ill_f = 1'b0;
    it.misa_r = m_r;
    it.misa_f = m_f;
    it.tag = tag;
    q.push_back(it);
    if (wr) begin
      m_r = legal_misa(wd, 1'b1);
      m_f = legal_misa(wd, 1'b0);
    end
  endtask

  // monitor: compare on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp({it.tag, " rd red"},   XLEN'(rd_r),  XLEN'(it.rd_r));
        cmp({it.tag, " rs1 red"},  XLEN'(rs1_r), XLEN'(it.rs1_r));
        cmp({it.tag, " rs2 red"},  XLEN'(rs2_r), XLEN'(it.rs2_r));
        cmp({it.tag, " ill red"},  XLEN'(ill_r), XLEN'(it.ill_r));
        cmp({it.tag, " rd full"},  XLEN'(rd_f),  XLEN'(it.rd_f));
        cmp({it.tag, " rs1 full"}, XLEN'(rs1_f), XLEN'(it.rs1_f));
        cmp({it.tag, " rs2 full"}, XLEN'(rs2_f), XLEN'(it.rs2_f));
        cmp({it.tag, " ill full"}, XLEN'(ill_f), XLEN'(it.ill_f));
        cmp({it.tag, " misa red"}, misa_r, it.misa_r);
        cmp({it.tag, " misa full"}, misa_f, it.misa_f);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2);
    return {7'h00, s2, s1, 3'b000, d, 7'h33};
  endfunction

  initial begin
    m_r = legal_misa('0, 1'b1);
    m_f = legal_misa('0, 1'b0);
    #12;
    rst_n = 1'b1;
    // R7 reset state
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b111, 1'b0, '0, "R7 reset");
    // R1 R2 R3: sweep each field alone, all fields enabled
    for (int v = 0; v < 32; v++) drive(mk(5'(v), 5'd0, 5'd0), 1'b0, 3'b111, 1'b0, '0, "R1 R2 R3 rd sweep");
    for (int v = 0; v < 32; v++) drive(mk(5'd0, 5'(v), 5'd0), 1'b0, 3'b111, 1'b0, '0, "R1 R2 R3 rs1 sweep");
    for (int v = 0; v < 32; v++) drive(mk(5'd0, 5'd0, 5'(v)), 1'b0, 3'b111, 1'b0, '0, "R1 R2 R3 rs2 sweep");
    // R6 several fields bad at once, and mixed
    drive(mk(5'd31, 5'd17, 5'd16), 1'b0, 3'b111, 1'b0, '0, "R6 all bad");
    drive(mk(5'd2, 5'd1, 5'd20), 1'b0, 3'b111, 1'b0, '0, "R6 one bad");
    // R4 reserved values in disabled fields
    drive(mk(5'd31, 5'd31, 5'd31), 1'b0, 3'b000, 1'b0, '0, "R4 none used");
    drive(mk(5'd16, 5'd3, 5'd3), 1'b0, 3'b110, 1'b0, '0, "R4 rd off");
    drive(mk(5'd3, 5'd24, 5'd3), 1'b0, 3'b101, 1'b0, '0, "R4 rs1 off");
    drive(mk(5'd3, 5'd3, 5'd30), 1'b0, 3'b011, 1'b0, '0, "R4 rs2 off");
    drive(mk(5'd3, 5'd3, 5'd30), 1'b0, 3'b100, 1'b0, '0, "R4 rs2 only");
    // R5 compressed fields, upper bits set to reserved-looking values
    for (int v = 0; v < 8; v++)
      drive({7'h7f, 5'h1f, 3'b111, 2'b11, 3'(v), 2'b11, 3'(7 - v), 2'b01}, 1'b1, 3'b111, 1'b0, '0, "R5 compressed");
    // R8 software writes
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b1, '1, "R8 write ones");
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b0, 32'h1234_5678, "R8 hold");
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b1, '0, "R8 write zero");
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b1, 32'h0000_0110, "R8 base only");
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b1, 32'hA5A5_5AEF, "R8 pattern");
    drive(mk(5'd0, 5'd0, 5'd0), 1'b0, 3'b000, 1'b0, '0, "R8 final");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule